// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the array address for each beat of a four-beat burst in a synchronous SRAM or in a controller that drives one. A load cycle captures an external start address. Each advance cycle after that steps the low two address bits through the next beat. The bits above them stay fixed. The block never touches the array or the data bus. Its only job is to present the right address on every beat.

A single static input selects the beat ordering. In linear order the low bits count up modulo four from the start value and wrap within the aligned group of four. In interleaved order the low bits are the start value XOR a beat count that runs 0, 1, 2, 3. The same `advance` input chooses between loading a new start address (low) and stepping the current burst (high). A stall input freezes all state. The chip-select qualifier decides whether a load cycle starts a burst or ends it.

The controller is a five-state machine:
- `ST_IDLE` means no burst is in progress.
- `ST_BEAT0` to `ST_BEAT3` hold the beat index of the burst.

The transitions are:
- **LOAD**: a selected load cycle moves any state to `ST_BEAT0`.
- **STOP**: a deselected load cycle moves any state to `ST_IDLE`.
- **STEP**: an advance cycle moves `ST_BEATn` to `ST_BEATn+1`.
- **WRAP**: an advance cycle moves `ST_BEAT3` to `ST_BEAT0`.
- **PARK**: an advance cycle leaves `ST_IDLE` where it is.
- **HOLD**: a stall keeps every state where it is.

All state registers are updated on the rising clock edge. The outputs are combinational from those registers, so a new address appears right after the edge that caused it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `burst_active` is 0 and `cur_addr` is 0 until the first load.
- R2: A clock edge that samples `stall`=0, `chip_sel`=1 and `advance`=0 loads `ext_addr`. After that edge, `cur_addr` equals the loaded value and `burst_active` is 1.
- R3: With `order_il`=0 (linear), each edge that samples `stall`=0 and `advance`=1 during a burst sets `cur_addr[1:0]` to the previous value plus 1 modulo 4. For example, a start of 2 gives 2, 3, 0, 1.
- R4: With `order_il`=1 (interleaved), beat k of a burst has `cur_addr[1:0]` = start[1:0] XOR k. For example, a start of 1 gives 1, 0, 3, 2.
- R5: On an advance edge, `ext_addr` and `chip_sel` are ignored, and `cur_addr[ADDR_W-1:2]` keeps its loaded value.
- R6: The fourth advance after a load wraps back to the start address, and `burst_active` stays 1.
- R7: An edge that samples `stall`=0, `chip_sel`=0 and `advance`=0 ends the burst. After that edge, `burst_active` is 0 and `cur_addr` shows the start address of the last loaded burst.
- R8: An advance edge while no burst is active has no effect on either output.
- R9: An edge that samples `stall`=1 changes nothing. Both outputs keep their values whatever the other inputs are.
- R10: A selected load during a burst restarts the sequence at beat 0 of the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | High freezes all state for the cycle |
| chip_sel | input | 1 | High marks a load cycle as a burst start; low marks it as a stop |
| advance | input | 1 | High steps the burst; low is a load cycle |
| order_il | input | 1 | Static beat order: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | Start address captured on a selected load |
| cur_addr | output | ADDR_W | Address of the current beat |
| burst_active | output | 1 | High while a burst is in progress |

## Verification
The bench targets the following corner cases:
- **Wrap after the fourth beat.** A counter that carried out of the low bits would move into the next group of four instead of returning to the start.
- **Linear start of 3.** This exposes a linear sequence that saturates or resets to zero instead of wrapping to 0, 1, 2.
- **Interleaved starts of 1 and 3.** These catch an ordering that adds instead of XORs.
- **Changing `ext_addr` during advance cycles.** This reveals upper bits that follow the input instead of the load.
- **Stalls placed on load and deselect cycles.** A design that let a stalled edge through would restart the burst or drop it.
- **Advance in idle.** This catches a counter that runs with no burst active.
- **Reload in mid-burst.** This catches a beat index that is not cleared on a new load.

// File: rtl/bac_pkg.sv
package bac_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } bac_state_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } bac_order_e;

    // Beat index carried by a state; idle reads as beat 0.
    function automatic logic [BEAT_W-1:0] beat_of(input bac_state_e st);
        logic [BEAT_W-1:0] b;
        unique case (st)
            ST_BEAT1: b = 2'd1;
            ST_BEAT2: b = 2'd2;
            ST_BEAT3: b = 2'd3;
            default:  b = 2'd0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/bac_ctrl_fsm.sv
module bac_ctrl_fsm
    import bac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stall,
    input  logic       chip_sel,
    input  logic       advance,
    output bac_state_e state_q,
    output logic       load_en,
    output logic       active
);

    bac_state_e state_d;
    logic       take_load;
    logic       take_stop;
    logic       take_step;

    assign take_load = !stall && !advance && chip_sel;
    assign take_stop = !stall && !advance && !chip_sel;
    assign take_step = !stall && advance;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection: LOAD, STOP, STEP, WRAP, PARK, HOLD
    always_comb begin
        state_d = state_q;
        if (take_load) begin
            state_d = ST_BEAT0;
        end else if (take_stop) begin
            state_d = ST_IDLE;
        end else if (take_step) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BEAT0: state_d = ST_BEAT1;
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        load_en = take_load;
        active  = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/bac_base_reg.sv
module bac_base_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load_en) begin
            base_q <= ext_addr;
        end
    end

endmodule

// File: rtl/bac_beat_map.sv
module bac_beat_map
    import bac_pkg::*;
(
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_il,
    output logic [BEAT_W-1:0] addr_lo
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    // Linear order: modulo add inside the aligned group.
    assign lin_lo = start_lo + beat;

    // Interleaved order: per-bit XOR of start and beat.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
        assign ilv_lo[i] = start_lo[i] ^ beat[i];
    end

    always_comb begin
        unique case (bac_order_e'(order_il))
            ORD_INTERLEAVE: addr_lo = ilv_lo;
            default:        addr_lo = lin_lo;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bac_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              chip_sel,
    input  logic              advance,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              burst_active
);

    localparam int HI_W = ADDR_W - BEAT_W;

    bac_state_e        state_q;
    logic              load_en;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] addr_lo;

    bac_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .chip_sel (chip_sel),
        .advance  (advance),
        .state_q  (state_q),
        .load_en  (load_en),
        .active   (burst_active)
    );

    bac_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .ext_addr (ext_addr),
        .base_q   (base_q)
    );

    assign beat = beat_of(state_q);

    bac_beat_map u_map (
        .start_lo (base_q[BEAT_W-1:0]),
        .beat     (beat),
        .order_il (order_il),
        .addr_lo  (addr_lo)
    );

    always_comb begin
        cur_addr = {base_q[ADDR_W-1 -: HI_W], addr_lo};
    end

endmodule

// File: rtl/bac_checker.sv
module bac_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              chip_sel,
    input logic              advance,
    input logic              order_il,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              burst_active
);

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && chip_sel && !advance) |=> (burst_active && cur_addr == $past(ext_addr))); // R2

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance && burst_active && !order_il)
        |=> (cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1))); // R3

    AST_HIGH_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))); // R5

    AST_STILL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance && burst_active) |=> burst_active); // R6

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !chip_sel && !advance) |=> !burst_active); // R7

    AST_IDLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance && !burst_active) |=> (!burst_active && $stable(cur_addr))); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $stable(order_il)) |=> ($stable(cur_addr) && $stable(burst_active))); // R9

endmodule

bind burst_addr_seq bac_checker #(.ADDR_W(ADDR_W)) u_bac_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall        (stall),
    .chip_sel     (chip_sel),
    .advance      (advance),
    .order_il     (order_il),
    .ext_addr     (ext_addr),
    .cur_addr     (cur_addr),
    .burst_active (burst_active)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;

    localparam int AW = 16;
    localparam int NV = 18;

    typedef struct packed {
        logic          stall;
        logic          sel;
        logic          adv;
        logic          il;
        logic [AW-1:0] ext;
        logic [AW-1:0] exp_addr;
        logic          exp_act;
        logic [3:0]    req;
    } vec_t;

    // stall sel adv il ext exp_addr exp_act req
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 1'b0, 16'h1234, 16'h0000, 1'b0, 4'd8 },  // R8 advance in idle
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h1232, 16'h1232, 1'b1, 4'd2 },  // R2 linear load
        '{1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h1233, 1'b1, 4'd5 },  // R5 ext ignored, R3
        '{1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h1230, 1'b1, 4'd3 },  // R3
        '{1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h1231, 1'b1, 4'd3 },  // R3
        '{1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h1232, 1'b1, 4'd6 },  // R6 wrap
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0BAD, 16'h1232, 1'b1, 4'd9 },  // R9 stalled load
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h1232, 1'b0, 4'd7 },  // R7 stop
        '{1'b0, 1'b1, 1'b0, 1'b1, 16'h4561, 16'h4561, 1'b1, 4'd2 },  // R2 interleaved load
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h4560, 1'b1, 4'd4 },  // R4
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h4563, 1'b1, 4'd4 },  // R4
        '{1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h4563, 1'b1, 4'd9 },  // R9 stalled advance
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h4562, 1'b1, 4'd4 },  // R4
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h4561, 1'b1, 4'd6 },  // R6 wrap
        '{1'b0, 1'b1, 1'b0, 1'b1, 16'h7773, 16'h7773, 1'b1, 4'd10},  // R10 reload mid-burst
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h7772, 1'b1, 4'd4 },  // R4 start 3
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h7772, 1'b1, 4'd9 },  // R9 stalled stop
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'h5555, 16'h7771, 1'b1, 4'd5 }   // R5 sel ignored on advance
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          chip_sel = 1'b0;
    logic          advance = 1'b0;
    logic          order_il = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] cur_addr;
    logic          burst_active;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall        (stall),
        .chip_sel     (chip_sel),
        .advance      (advance),
        .order_il     (order_il),
        .ext_addr     (ext_addr),
        .cur_addr     (cur_addr),
        .burst_active (burst_active)
    );

    task automatic check(input string req, input logic [AW-1:0] ea, input logic eact);
        n_tests++;
        if (cur_addr !== ea || burst_active !== eact) begin
            n_fail++;
            $display("FAIL %s: addr=%h active=%b expected addr=%h active=%b",
                     req, cur_addr, burst_active, ea, eact);
        end
    endtask

    task automatic cycle(input logic s, input logic cs, input logic a,
                         input logic o, input logic [AW-1:0] e);
        @(negedge clk);
        stall = s; chip_sel = cs; advance = a; order_il = o; ext_addr = e;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1;
        check("R1", 16'h0000, 1'b0);                                  // R1 during reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 16'h0000, 1'b0);                                  // R1 after release

        for (int i = 0; i < NV; i++) begin
            cycle(VECS[i].stall, VECS[i].sel, VECS[i].adv, VECS[i].il, VECS[i].ext);
            check($sformatf("R%0d", VECS[i].req), VECS[i].exp_addr, VECS[i].exp_act);
        end

        // R3 linear start 3: 3,0,1,2,3
        cycle(1'b0, 1'b1, 1'b0, 1'b0, 16'h00A3);
        check("R3", 16'h00A3, 1'b1);
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 16'h0000);
        check("R3", 16'h00A0, 1'b1);
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 16'h0000);
        check("R3", 16'h00A1, 1'b1);
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 16'h0000);
        check("R3", 16'h00A2, 1'b1);
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 16'h0000);
        check("R6", 16'h00A3, 1'b1);

        // R1 reset in mid-burst
        cycle(1'b0, 1'b1, 1'b1, 1'b0, 16'h0000);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", 16'h0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 advance after reset stays idle
        cycle(1'b0, 1'b1, 1'b1, 1'b1, 16'h2222);
        check("R8", 16'h0000, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule